// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a two-wire serial memory. It runs entirely on a system clock. It oversamples the serial clock and data lines through synchronisers and only ever pulls the data line low, through an open-drain enable. When a START condition arrives, the block takes in a device address byte. It answers only if the upper bits carry the fixed memory prefix and the next three bits match its strap inputs.

A write command carries two word-address bytes and then data bytes. Each data byte is stored in an internal byte array, and the low address bits advance within the current page. A STOP at the end of a write with data starts a timed internal write cycle. For the length of that cycle the block refuses to acknowledge its address, so a host can poll until the cycle is over. A read command returns bytes from a single address counter, which persists between transactions and wraps over the whole array. Because of that counter, a write command carrying only the address, followed by a repeated START and a read, gives a read at any chosen address.

Top module: `twi_mem_target`

## Requirements
- R1: A device address byte is acknowledged only when bits 7..4 equal 1010, bits 3..1 equal `strap_i`, and no internal write cycle is running. Bit 0 selects the direction: 1 means read and 0 means write.
- R2: After a device address it does not accept, the block leaves the data line released for every later clock until the next START.
- R3: An acknowledge is the block holding the data line low during the ninth clock of a byte. The block changes its data line drive only while the serial clock is low.
- R4: A write command takes two word-address bytes and acknowledges both. The low `ADDR_W` bits of {first byte, second byte} load the address counter, and all higher bits are ignored. Each following data byte is acknowledged and stored at the counter.
- R5: After each stored data byte, the low `PAGE_W` bits of the counter advance by one and wrap inside the page, while the upper bits stay fixed. If more than a page of data is sent, the earlier bytes of that page are overwritten.
- R6: A STOP or START that ends a write in which at least one data byte was stored starts an internal write cycle of `WR_CYCLES` clocks. During that cycle no device address is acknowledged. Once the cycle ends, the address is acknowledged again.
- R7: A read command returns the byte at the counter, most significant bit first, and the counter then advances by one. Going past the highest address wraps the counter to zero.
- R8: A master acknowledge after a read byte makes the block send the next byte. A master not-acknowledge makes the block release the line and ignore further clocks until the next START.
- R9: A START that follows the word-address bytes of a write, before any data byte, abandons the write without starting an internal write cycle and keeps the loaded address. A read that follows then starts at that address.
- R10: The counter keeps its value across transactions. A new read continues at the last accessed address plus one, which after a page write is the page-wrapped next address.
- R11: While reset is asserted, and right after it, the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 3 | Device address strap pins |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The hardest condition to reach from the ports is a device address that arrives while the internal write cycle is still running. The bench gets there by finishing a page write with STOP and addressing the block again at once, well inside a deliberately short write cycle. It then keeps polling until the acknowledge comes back. Page wrap and counter persistence are reached by a write that overruns its page from an offset in the middle of it. Right after that write, a bare current-address read shows where the counter stopped. Array wrap is exercised by a single sequential read that runs past the last address of a small array.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } phase_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam logic [3:0] CNT_ARM    = 4'd15;
endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_sync_n,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] rst_q;
  logic [1:0] scl_meta_q, sda_meta_q;
  logic       scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      scl_meta_q <= 2'b11;
      sda_meta_q <= 2'b11;
      scl_p_q    <= 1'b1;
      sda_p_q    <= 1'b1;
    end else begin
      scl_meta_q <= {scl_meta_q[0], scl_i};
      sda_meta_q <= {sda_meta_q[0], sda_i};
      scl_p_q    <= scl_meta_q[1];
      sda_p_q    <= sda_meta_q[1];
    end
  end

  assign scl_s     = scl_meta_q[1];
  assign sda_s     = sda_meta_q[1];
  assign scl_rise  = scl_s & ~scl_p_q;
  assign scl_fall  = ~scl_s & scl_p_q;
  assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/twi_page_store.sv
module twi_page_store #(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              commit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] tmr_q, tmr_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end
  assign rd_data = mem[rd_addr];

  always_comb begin
    tmr_d = tmr_q;
    if (commit)            tmr_d = CW'(WR_CYCLES);
    else if (tmr_q != '0)  tmr_d = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign busy = (tmr_q != '0);
endmodule

// File: rtl/twi_mem_target.sv
module twi_mem_target
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);

  logic rst_sync_n, scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  phase_t            state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d, tx_q, tx_d, ahi_q, ahi_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_inc, addr_page;
  logic              rw_q, rw_d, mack_q, mack_d, wrote_q, wrote_d, oe_q, oe_d;
  logic              wr_en, commit, busy, rd_load, dev_hit;
  logic [7:0]        rd_data;
  logic [15:0]       word_addr;

  twi_line_cond u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .rst_sync_n(rst_sync_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_page_store #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(addr_q),
    .wr_data(sh_q), .commit(commit), .rd_addr(addr_q),
    .rd_data(rd_data), .busy(busy)
  );

  assign addr_inc  = addr_q + 1'b1;
  assign addr_page = (addr_q & ~PAGE_MASK) | (addr_inc & PAGE_MASK);
  assign word_addr = {ahi_q, sh_q};
  assign dev_hit   = (sh_q[7:4] == DEV_PREFIX) && (sh_q[3:1] == strap_i) && !busy;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ahi_d   = ahi_q;
    addr_d  = addr_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    wrote_d = wrote_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    commit  = 1'b0;
    rd_load = 1'b0;

    if (start_det) begin
      commit  = wrote_q;
      wrote_d = 1'b0;
      state_d = ST_DEV;
      cnt_d   = CNT_ARM;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      commit  = wrote_q;
      wrote_d = 1'b0;
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      if (scl_rise && state_q != ST_IDLE) begin
        if (state_q != ST_RDAT && cnt_q < 4'd8) sh_d = {sh_q[6:0], sda_s};
        if (state_q == ST_RDAT && cnt_q == 4'd8) mack_d = ~sda_s;
      end
      if (scl_fall && state_q != ST_IDLE) begin
        if (cnt_q == CNT_ARM) begin
          cnt_d = 4'd0;
        end else if (state_q == ST_RDAT) begin
          if (cnt_q < 4'd7) begin
            tx_d  = {tx_q[6:0], 1'b0};
            oe_d  = ~tx_q[6];
            cnt_d = cnt_q + 1'b1;
          end else if (cnt_q == 4'd7) begin
            oe_d  = 1'b0;
            cnt_d = 4'd8;
          end else if (mack_q) begin
            rd_load = 1'b1;
          end else begin
            oe_d    = 1'b0;
            state_d = ST_IDLE;
          end
        end else if (cnt_q == 4'd7) begin
          cnt_d = 4'd8;
          case (state_q)
            ST_DEV: begin
              if (dev_hit) begin
                oe_d = 1'b1;
                rw_d = sh_q[0];
              end else begin
                state_d = ST_IDLE;
              end
            end
            ST_AHI: begin
              ahi_d = sh_q;
              oe_d  = 1'b1;
            end
            ST_ALO: begin
              addr_d = word_addr[ADDR_W-1:0];
              oe_d   = 1'b1;
            end
            default: begin
              wr_en   = 1'b1;
              wrote_d = 1'b1;
              addr_d  = addr_page;
              oe_d    = 1'b1;
            end
          endcase
        end else if (cnt_q == 4'd8) begin
          oe_d  = 1'b0;
          cnt_d = 4'd0;
          case (state_q)
            ST_DEV:  if (rw_q) rd_load = 1'b1;
                     else      state_d = ST_AHI;
            ST_AHI:  state_d = ST_ALO;
            default: state_d = ST_WDAT;
          endcase
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (rd_load) begin
        tx_d    = rd_data;
        oe_d    = ~rd_data[7];
        addr_d  = addr_inc;
        state_d = ST_RDAT;
        cnt_d   = 4'd0;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      sh_q    <= 8'd0;
      tx_q    <= 8'd0;
      ahi_q   <= 8'd0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      wrote_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ahi_q   <= ahi_d;
      addr_q  <= addr_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      wrote_q <= wrote_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/twi_mem_target_chk.sv
module twi_mem_target_chk
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              scl_fall,
  input phase_t            state_q,
  input logic [3:0]        cnt_q,
  input logic [7:0]        sh_q,
  input logic [2:0]        strap_i,
  input logic              busy,
  input logic              wr_en,
  input logic              rd_load,
  input logic [ADDR_W-1:0] addr_q,
  input logic              sda_oe_o
);
  logic dev_decide;
  assign dev_decide = scl_fall && (state_q == ST_DEV) && (cnt_q == 4'd7);

  assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);

  assert_prefix_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_decide && sh_q[7:4] != 4'b1010) |=> (state_q == ST_IDLE && !sda_oe_o));

  assert_strap_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_decide && sh_q[3:1] != strap_i) |=> (state_q == ST_IDLE && !sda_oe_o));

  assert_busy_noack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_decide && busy) |=> !sda_oe_o);

  assert_no_store_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy);

  assert_read_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));
endmodule

bind twi_mem_target twi_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .state_q(state_q), .cnt_q(cnt_q), .sh_q(sh_q), .strap_i(strap_i),
  .busy(busy), .wr_en(wr_en), .rd_load(rd_load), .addr_q(addr_q),
  .sda_oe_o(sda_oe_o)
);

// File: tb/twi_mem_target_tb_top.sv
module twi_mem_target_tb_top;
  localparam int AW = 6;
  localparam int PW = 3;
  localparam int NB = 1 << AW;
  localparam logic [7:0] DEVW = 8'hA6;
  localparam logic [7:0] DEVR = 8'hA7;

  logic       clk, rst_n, scl, m_low;
  logic [2:0] strap;
  wire        dut_oe;
  wire        sda_line = ~(m_low | dut_oe);

  int n_chk = 0;
  int n_fail = 0;
  int hi_changes = 0;
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;
  logic [7:0] model [NB];

  twi_mem_target #(.ADDR_W(AW), .PAGE_W(PW), .WR_CYCLES(600)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(dut_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && dut_oe != prev_oe) hi_changes++;
    prev_oe  = dut_oe;
    prev_scl = scl;
  end

  task automatic check(input string rq, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dv(input int a);
    return 8'((a * 37 + 11) ^ 8'hA5);
  endfunction

  task automatic wq();
    repeat (5) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic got);
    m_low = ~b; wq();
    scl = 1'b1; wq();
    got = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic start_c();
    m_low = 1'b0; wq();
    scl = 1'b1; wq();
    m_low = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic stop_c();
    m_low = 1'b1; wq();
    scl = 1'b1; wq();
    m_low = 1'b0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], g);
    clk_bit(1'b1, g);
    ack = ~g;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, g);
      d[i] = g;
    end
    clk_bit(~mack, g);
  endtask

  task automatic wait_ready();
    logic ack;
    int polls;
    logic done;
    polls = 0; done = 1'b0;
    while (!done && polls < 40) begin
      start_c(); send_byte(DEVW, ack); stop_c();
      if (ack) done = 1'b1; else polls++;
    end
    check("R6", int'(done), 1, "ack returns after write cycle");
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic ack;
    start_c();
    send_byte(DEVW, ack); check("R1", int'(ack), 1, "write command ack");
    send_byte(hi, ack);   check("R4", int'(ack), 1, "high address ack");
    send_byte(lo, ack);   check("R4", int'(ack), 1, "low address ack");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..R11 run: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack, g;
    logic [7:0] d;
    logic [3:0] bad [4];
    bad = '{4'b0010, 4'b1110, 4'b1011, 4'b1000};
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; strap = 3'b101;
    repeat (4) @(negedge clk);
    check("R11", int'(dut_oe), 0, "released in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R11", int'(dut_oe), 0, "released after reset");

    // R1 / R2 sweep over straps, address bits and bad prefixes
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        start_c();
        send_byte({4'b1010, 3'(a), 1'b0}, ack);
        check("R1", int'(ack), int'(a == s), "strap compare");
        if (!ack) begin
          send_byte(8'h00, ack);
          check("R2", int'(ack), 0, "no drive after mismatch");
        end
        stop_c();
      end
      for (int k = 0; k < 4; k++) begin
        start_c();
        send_byte({bad[k], 3'(s), 1'b1}, ack);
        check("R1", int'(ack), 0, "prefix compare");
        stop_c();
      end
    end
    strap = 3'b011;

    // R4 / R6: fill every page, upper address bits set to junk
    for (int pg = 0; pg < NB / 8; pg++) begin
      set_addr(8'hFF, {2'b11, 3'(pg), 3'b000});
      for (int i = 0; i < 8; i++) begin
        model[pg * 8 + i] = dv(pg * 8 + i);
        send_byte(dv(pg * 8 + i), ack);
        check("R4", int'(ack), 1, "data byte ack");
      end
      stop_c();
      start_c(); send_byte(DEVW, ack); stop_c();
      check("R6", int'(ack), 0, "no ack while writing");
      wait_ready();
    end

    // R9 / R7 / R8: random read from 0 running past the top
    set_addr(8'h00, 8'h00);
    start_c();
    send_byte(DEVR, ack); check("R9", int'(ack), 1, "read after dummy write");
    for (int i = 0; i < NB + 2; i++) begin
      recv_byte(d, i != NB + 1);
      check(i == 0 ? "R9" : (i >= NB ? "R7" : "R8"), int'(d), int'(model[i % NB]), "sequential data");
    end
    stop_c();

    // R10 current read continues; R8 nack releases
    start_c();
    send_byte(DEVR, ack);
    recv_byte(d, 1'b0);
    check("R10", int'(d), int'(model[2]), "current read after wrap");
    clk_bit(1'b1, g);
    check("R8", int'(g), 1, "line released after nack");
    stop_c();

    // R5 page overrun from offset 6 of page 2
    set_addr(8'h00, 8'd22);
    for (int i = 0; i < 10; i++) begin
      model[16 + ((6 + i) % 8)] = 8'(8'hE0 + i);
      send_byte(8'(8'hE0 + i), ack);
      check("R5", int'(ack), 1, "overrun data ack");
    end
    stop_c();
    wait_ready();
    start_c();
    send_byte(DEVR, ack);
    recv_byte(d, 1'b0);
    stop_c();
    check("R10", int'(d), int'(model[16]), "counter after page write");
    set_addr(8'h00, 8'd16);
    start_c();
    send_byte(DEVR, ack);
    for (int i = 0; i < 8; i++) begin
      recv_byte(d, i != 7);
      check("R5", int'(d), int'(model[16 + i]), "page wrap content");
    end
    stop_c();

    // R4 high address bits ignored
    set_addr(8'hFF, 8'hC5);
    start_c();
    send_byte(DEVR, ack);
    recv_byte(d, 1'b0);
    stop_c();
    check("R4", int'(d), int'(model[5]), "upper address bits ignored");

    check("R3", hi_changes, 0, "drive changes while clock high");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule